// File: doc/BRIEF.md
# Domain-Based Peripheral Access Checker

This block places every bus master in one of four isolation domains and checks each peripheral access against a policy word held for that peripheral. Configuration goes through a small register port. Each master has an assignment entry that holds its domain and a lock bit. Each peripheral has a policy entry that holds read and write rights for every domain, a semaphore-required flag and a lock bit. A lock can only be cleared by reset. Writes are registered. Reads of the configuration are combinational.

An access request names a master index, a peripheral index and a direction. In the same cycle the block finds the master's domain, picks the permission bit for that domain and direction from the peripheral's policy, and drives grant or deny. With the same lookup it also reports whether that peripheral requires a hardware semaphore. An index beyond the configured counts is always denied. A read-only identification word reports the sizes the block was built with.

Top module: `dom_access_checker`

## Requirements
- R1: After reset every master reads back as domain 0, unlocked (value 0x000). Every peripheral policy reads back 0x0FF: all four domains may read and write, with the semaphore flag and the lock cleared.
- R2: A granted read requires policy bit 2*d to be set, where d is the requesting master's domain.
- R3: A granted write requires policy bit 2*d+1 to be set, where d is the requesting master's domain.
- R4: Master assignment word layout: bits [1:0] hold the domain and bit 7 holds the lock. A write to space 0 changes the domain used for that master's later accesses.
- R5: While an assignment's lock bit is set, writes to that assignment leave it unchanged.
- R6: Policy word layout: bits [7:0] hold the permissions, bit 8 the semaphore flag and bit 9 the lock. While the lock bit is set, writes to that policy leave it unchanged.
- R7: An access whose master index is at or above NUM_MASTERS, or whose peripheral index is at or above NUM_PERIPH, is denied and reports no semaphore need. A configuration write to an out-of-range index changes no entry. A read of an out-of-range index returns 0.
- R8: `acc_sema_req` is 1 for a valid, in-range access exactly when bit 8 of the addressed peripheral's policy is set.
- R9: Space 2 reads the identification word. Bits [7:0] hold NUM_MASTERS, bits [15:8] hold the domain count (4), and bits [23:16] hold NUM_PERIPH. Writes to this space have no effect.
- R10: When `acc_valid` is low, `acc_grant` and `acc_sema_req` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_space | input | 2 | 0 master assignment, 1 peripheral policy, 2 identification |
| cfg_idx | input | IDX_W | Entry index within the space |
| cfg_wdata | input | 10 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_space/cfg_idx |
| acc_valid | input | 1 | Access request present |
| acc_master | input | IDX_W | Requesting master index |
| acc_periph | input | IDX_W | Target peripheral index |
| acc_write | input | 1 | 1 write, 0 read |
| acc_grant | output | 1 | Access allowed |
| acc_sema_req | output | 1 | Target needs a semaphore |

## Verification
A corrupted assignment or policy entry appears at once, in the same cycle, as a wrong grant for every master and peripheral that use that entry. It also shows as a wrong readback on the configuration port. A lock that fails to hold appears one clock after the offending write, as a changed readback and a changed grant. The bench therefore follows each write with both a readback and access probes, across domains whose read and write rights differ.

// File: rtl/dac_pkg.sv
package dac_pkg;
   localparam int NUM_DOMAINS = 4;
   localparam int DOM_W       = 2;
   localparam int PERM_W      = 2 * NUM_DOMAINS;
   localparam int WDATA_W     = 10;
   localparam int ASG_LOCK_B  = 7;
   localparam int POL_SEMA_B  = 8;
   localparam int POL_LOCK_B  = 9;

   typedef enum logic [1:0] {
      SP_MASTER = 2'd0,
      SP_POLICY = 2'd1,
      SP_IDENT  = 2'd2,
      SP_NONE   = 2'd3
   } cfg_space_e;
endpackage

// File: rtl/dac_master_table.sv
module dac_master_table
   import dac_pkg::*;
#(
   parameter int NUM_MASTERS = 8,
   parameter int IDX_W       = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [IDX_W-1:0]                      wr_idx,
   input  logic [DOM_W-1:0]                      wr_dom,
   input  logic                                  wr_lock,
   output logic [NUM_MASTERS-1:0][DOM_W-1:0]     dom_q,
   output logic [NUM_MASTERS-1:0]                lock_q
);
   for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i)) && !lock_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dom_q[i]  <= '0;
            lock_q[i] <= 1'b0;
         end else if (hit) begin
            dom_q[i]  <= wr_dom;
            lock_q[i] <= wr_lock;
         end
      end

      AST_ASG_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         lock_q[i] |=> ($stable(dom_q[i]) && lock_q[i])); // R5
   end
endmodule

// File: rtl/dac_policy_table.sv
module dac_policy_table
   import dac_pkg::*;
#(
   parameter int NUM_PERIPH = 16,
   parameter int IDX_W      = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [IDX_W-1:0]                      wr_idx,
   input  logic [WDATA_W-1:0]                    wr_data,
   output logic [NUM_PERIPH-1:0][PERM_W-1:0]     perm_q,
   output logic [NUM_PERIPH-1:0]                 sema_q,
   output logic [NUM_PERIPH-1:0]                 lock_q
);
   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(p)) && !lock_q[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            perm_q[p] <= '1;
            sema_q[p] <= 1'b0;
            lock_q[p] <= 1'b0;
         end else if (hit) begin
            perm_q[p] <= wr_data[PERM_W-1:0];
            sema_q[p] <= wr_data[POL_SEMA_B];
            lock_q[p] <= wr_data[POL_LOCK_B];
         end
      end

      AST_POL_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         lock_q[p] |=> ($stable(perm_q[p]) && $stable(sema_q[p]) && lock_q[p])); // R6
   end
endmodule

// File: rtl/dac_judge.sv
module dac_judge
   import dac_pkg::*;
#(
   parameter int NUM_MASTERS = 8,
   parameter int NUM_PERIPH  = 16,
   parameter int IDX_W       = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  acc_valid,
   input  logic [IDX_W-1:0]                      acc_master,
   input  logic [IDX_W-1:0]                      acc_periph,
   input  logic                                  acc_write,
   input  logic [NUM_MASTERS-1:0][DOM_W-1:0]     dom_tbl,
   input  logic [NUM_PERIPH-1:0][PERM_W-1:0]     perm_tbl,
   input  logic [NUM_PERIPH-1:0]                 sema_tbl,
   output logic                                  grant,
   output logic                                  sema_req
);
   localparam int MI_W = $clog2(NUM_MASTERS);
   localparam int PI_W = $clog2(NUM_PERIPH);

   logic              m_ok, p_ok;
   logic [DOM_W-1:0]  dom;
   logic [PERM_W-1:0] perm;
   logic [DOM_W:0]    bit_sel;

   assign m_ok    = acc_master < IDX_W'(NUM_MASTERS);
   assign p_ok    = acc_periph < IDX_W'(NUM_PERIPH);
   assign dom     = m_ok ? dom_tbl[acc_master[MI_W-1:0]] : '0;
   assign perm    = p_ok ? perm_tbl[acc_periph[PI_W-1:0]] : '0;
   // read right sits at 2*dom, write right one bit above it
   assign bit_sel = {dom, acc_write};

   assign grant    = acc_valid && m_ok && p_ok && perm[bit_sel];
   assign sema_req = acc_valid && m_ok && p_ok && sema_tbl[acc_periph[PI_W-1:0]];

   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!grant && !sema_req)); // R10
   AST_BAD_INDEX_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_master >= IDX_W'(NUM_MASTERS) || acc_periph >= IDX_W'(NUM_PERIPH))
         |-> (!grant && !sema_req)); // R7
endmodule

// File: rtl/dom_access_checker.sv
module dom_access_checker
   import dac_pkg::*;
#(
   parameter int NUM_MASTERS = 8,
   parameter int NUM_PERIPH  = 16,
   parameter int IDX_W       = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_space,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [9:0]         cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic               acc_valid,
   input  logic [IDX_W-1:0]   acc_master,
   input  logic [IDX_W-1:0]   acc_periph,
   input  logic               acc_write,
   output logic               acc_grant,
   output logic               acc_sema_req
);
   localparam int MI_W = $clog2(NUM_MASTERS);
   localparam int PI_W = $clog2(NUM_PERIPH);

   if (NUM_MASTERS < 2 || NUM_MASTERS > 255) begin : g_bad_masters
      $error("NUM_MASTERS must be 2..255");
   end
   if (NUM_PERIPH < 2 || NUM_PERIPH > 255) begin : g_bad_periph
      $error("NUM_PERIPH must be 2..255");
   end
   if ((2 ** IDX_W) <= NUM_MASTERS || (2 ** IDX_W) <= NUM_PERIPH) begin : g_bad_idx
      $error("IDX_W must reach one past the largest count");
   end

   logic [NUM_MASTERS-1:0][DOM_W-1:0] dom_q;
   logic [NUM_MASTERS-1:0]            asg_lock_q;
   logic [NUM_PERIPH-1:0][PERM_W-1:0] perm_q;
   logic [NUM_PERIPH-1:0]             sema_q;
   logic [NUM_PERIPH-1:0]             pol_lock_q;
   logic                              wr_asg, wr_pol;

   assign wr_asg = cfg_we && (cfg_space == SP_MASTER);
   assign wr_pol = cfg_we && (cfg_space == SP_POLICY);

   dac_master_table #(.NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)) u_masters (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_asg),
      .wr_idx  (cfg_idx),
      .wr_dom  (cfg_wdata[DOM_W-1:0]),
      .wr_lock (cfg_wdata[ASG_LOCK_B]),
      .dom_q   (dom_q),
      .lock_q  (asg_lock_q)
   );

   dac_policy_table #(.NUM_PERIPH(NUM_PERIPH), .IDX_W(IDX_W)) u_policies (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_pol),
      .wr_idx  (cfg_idx),
      .wr_data (cfg_wdata),
      .perm_q  (perm_q),
      .sema_q  (sema_q),
      .lock_q  (pol_lock_q)
   );

   dac_judge #(.NUM_MASTERS(NUM_MASTERS), .NUM_PERIPH(NUM_PERIPH), .IDX_W(IDX_W)) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_master (acc_master),
      .acc_periph (acc_periph),
      .acc_write  (acc_write),
      .dom_tbl    (dom_q),
      .perm_tbl   (perm_q),
      .sema_tbl   (sema_q),
      .grant      (acc_grant),
      .sema_req   (acc_sema_req)
   );

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_space)
         SP_MASTER: if (cfg_idx < IDX_W'(NUM_MASTERS)) begin
            cfg_rdata[DOM_W-1:0]  = dom_q[cfg_idx[MI_W-1:0]];
            cfg_rdata[ASG_LOCK_B] = asg_lock_q[cfg_idx[MI_W-1:0]];
         end
         SP_POLICY: if (cfg_idx < IDX_W'(NUM_PERIPH)) begin
            cfg_rdata[PERM_W-1:0] = perm_q[cfg_idx[PI_W-1:0]];
            cfg_rdata[POL_SEMA_B] = sema_q[cfg_idx[PI_W-1:0]];
            cfg_rdata[POL_LOCK_B] = pol_lock_q[cfg_idx[PI_W-1:0]];
         end
         SP_IDENT: cfg_rdata = {8'h00, 8'(NUM_PERIPH), 8'(NUM_DOMAINS), 8'(NUM_MASTERS)};
         default:  cfg_rdata = '0;
      endcase
   end

   AST_GRANT_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_grant |-> (acc_valid && acc_master < IDX_W'(NUM_MASTERS)
                     && acc_periph < IDX_W'(NUM_PERIPH))); // R7
endmodule

// File: tb/dom_access_checker_test.sv
module dom_access_checker_test;
   localparam int NM = 8;
   localparam int NP = 16;
   localparam int IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_space = 2'd0;
   logic [IW-1:0] cfg_idx = '0;
   logic [9:0]    cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          acc_valid = 1'b0;
   logic [IW-1:0] acc_master = '0;
   logic [IW-1:0] acc_periph = '0;
   logic          acc_write = 1'b0;
   logic          acc_grant;
   logic          acc_sema_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dom_access_checker #(.NUM_MASTERS(NM), .NUM_PERIPH(NP), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_space(cfg_space),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .acc_valid(acc_valid), .acc_master(acc_master), .acc_periph(acc_periph),
      .acc_write(acc_write), .acc_grant(acc_grant), .acc_sema_req(acc_sema_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sp, input int idx, input logic [9:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_space = sp; cfg_idx = IW'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] sp, input int idx,
                           input logic [31:0] exp);
      cfg_space = sp; cfg_idx = IW'(idx);
      #1;
      check(req, cfg_rdata, exp);
   endtask

   task automatic acc_check(input string req, input logic v, input int m, input int p,
                            input logic w, input logic exp_g, input logic exp_s);
      acc_valid = v; acc_master = IW'(m); acc_periph = IW'(p); acc_write = w;
      #1;
      check({req, " grant"}, {31'b0, acc_grant}, {31'b0, exp_g});
      check({req, " sema"}, {31'b0, acc_sema_req}, {31'b0, exp_s});
      acc_valid = 1'b0;
   endtask

   task automatic t_reset();
      rd_check("R1 master0", 2'd0, 0, 32'h0);
      rd_check("R1 master7", 2'd0, NM-1, 32'h0);
      rd_check("R1 policy0", 2'd1, 0, 32'h0FF);
      rd_check("R1 policy15", 2'd1, NP-1, 32'h0FF);
      acc_check("R1 default rd", 1'b1, 5, 9, 1'b0, 1'b1, 1'b0);
      acc_check("R1 default wr", 1'b1, 7, 15, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_ident();
      rd_check("R9 ident", 2'd2, 0, 32'h0010_0408);
      wr(2'd2, 0, 10'h3FF);
      rd_check("R9 ident after write", 2'd2, 0, 32'h0010_0408);
   endtask

   task automatic t_rules();
      // d0 RW, d1 none, d2 read only, d3 write only
      wr(2'd1, 3, 10'h093);
      wr(2'd0, 1, 10'h001);
      wr(2'd0, 2, 10'h002);
      wr(2'd0, 3, 10'h003);
      rd_check("R4 master3 readback", 2'd0, 3, 32'h003);
      acc_check("R2 d0 read",  1'b1, 0, 3, 1'b0, 1'b1, 1'b0);
      acc_check("R3 d0 write", 1'b1, 0, 3, 1'b1, 1'b1, 1'b0);
      acc_check("R2 d1 read",  1'b1, 1, 3, 1'b0, 1'b0, 1'b0);
      acc_check("R3 d1 write", 1'b1, 1, 3, 1'b1, 1'b0, 1'b0);
      acc_check("R2 d2 read",  1'b1, 2, 3, 1'b0, 1'b1, 1'b0);
      acc_check("R3 d2 write", 1'b1, 2, 3, 1'b1, 1'b0, 1'b0);
      acc_check("R2 d3 read",  1'b1, 3, 3, 1'b0, 1'b0, 1'b0);
      acc_check("R3 d3 write", 1'b1, 3, 3, 1'b1, 1'b1, 1'b0);
      wr(2'd0, 2, 10'h000);
      acc_check("R4 remap to d0", 1'b1, 2, 3, 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_sema();
      wr(2'd1, 5, 10'h1FF);
      rd_check("R8 policy5", 2'd1, 5, 32'h1FF);
      acc_check("R8 sema set", 1'b1, 0, 5, 1'b0, 1'b1, 1'b1);
      acc_check("R8 sema clear", 1'b1, 0, 4, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_asg_lock();
      wr(2'd0, 4, 10'h081);
      rd_check("R5 locked value", 2'd0, 4, 32'h081);
      wr(2'd0, 4, 10'h003);
      rd_check("R5 write ignored", 2'd0, 4, 32'h081);
      acc_check("R5 still d1", 1'b1, 4, 3, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_pol_lock();
      wr(2'd1, 6, 10'h205);
      rd_check("R6 locked value", 2'd1, 6, 32'h205);
      wr(2'd1, 6, 10'h0FF);
      rd_check("R6 write ignored", 2'd1, 6, 32'h205);
      acc_check("R6 d0 write denied", 1'b1, 0, 6, 1'b1, 1'b0, 1'b0);
      acc_check("R6 d0 read granted", 1'b1, 0, 6, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_range();
      acc_check("R7 master out", 1'b1, NM, 0, 1'b0, 1'b0, 1'b0);
      acc_check("R7 periph out", 1'b1, 0, NP, 1'b0, 1'b0, 1'b0);
      wr(2'd0, NM, 10'h003);
      rd_check("R7 no alias master0", 2'd0, 0, 32'h0);
      wr(2'd1, NP, 10'h000);
      rd_check("R7 no alias policy0", 2'd1, 0, 32'h0FF);
      rd_check("R7 oob read", 2'd0, NM, 32'h0);
   endtask

   task automatic t_idle();
      acc_check("R10 idle", 1'b0, 0, 5, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_rules();
      t_sema();
      t_asg_lock();
      t_pol_lock();
      t_range();
      t_idle();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule